// File: doc/BRIEF.md
# Lockable Round-Robin Translation Buffer

This block is a small, fully associative address translation cache for a device-side memory management unit. Each entry maps one virtual page of 4 KB, 64 KB, 1 MB or 16 MB to a physical page. A lookup port takes a 32-bit device address and reports hit or miss, with the translated address, one clock later.

A command port lets software manage the entries:
- load an entry from a CAM word and a RAM word;
- invalidate every entry whose page covers a given address;
- invalidate all entries;
- write the two-field lock state.

The lock state holds a base index and a victim index. Entries below the base are pinned and are never picked for replacement. Ordinary loads rotate through the entries from the base upward. Setting the victim index selects which entry appears on the read-back outputs.

Top module: `xlat_tlb`

## Requirements
- R1: CAM word fields: bits [31:12] virtual tag, bit 3 pin request, bit 2 valid, bits [1:0] size code (0 = 4 KB, 1 = 64 KB, 2 = 1 MB, 3 = 16 MB). RAM word bits [31:12] hold the physical page and bits [11:0] are attribute bits. For a lookup request, when a valid entry's tag equals the address on all bits above its page size, the next cycle shows hit = 1 and phys = (page bits above the size) OR (address bits below the size).
- R2: A lookup request that matches no valid entry gives miss = 1, hit = 0 and phys = 0 in the next cycle. A cycle without a request gives hit = 0 and miss = 0 in the next cycle.
- R3: When several valid entries match one address, the entry with the lowest index supplies the translation.
- R4: A load without the pin request writes the entry at the victim index. The victim index then increments, and on reaching the entry count it wraps to the current base, not to zero.
- R5: A load with the pin request writes the entry at the base index and increments the base. The victim index becomes the old base plus one, wrapping to the new base on reaching the entry count.
- R6: A load issued while the base equals the entry count is refused. The busy output is 1 in the next cycle, and no entry, base or victim changes.
- R7: A flush-by-address invalidates every valid entry whose span [start, start + size) contains the address, where the size comes from that entry's own size code. An address one past the end of a span leaves that entry valid.
- R8: A global flush invalidates all entries and sets both base and victim to zero.
- R9: A lock write sets base and victim from the command inputs. The read-back outputs always show the entry at the victim index. Read-back CAM bit 3 is 0, and the RAM word comes back whole, attribute bits included.
- R10: After reset, all entries are invalid, base and victim are zero, and busy, hit and miss are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| lkReq | input | 1 | Lookup request |
| lkAddr | input | 32 | Device address to translate |
| lkHit | output | 1 | Lookup hit, one cycle after the request |
| lkMiss | output | 1 | Lookup miss, one cycle after the request |
| lkPhys | output | 32 | Translated address, zero on a miss |
| cmdValid | input | 1 | Command strobe |
| cmdOp | input | 3 | Command: 0 none, 1 load, 2 flush by address, 3 flush all, 4 lock write |
| cmdCam | input | 32 | CAM word for a load |
| cmdRam | input | 32 | RAM word for a load |
| cmdAddr | input | 32 | Address for a flush by address |
| cmdBase | input | CW | Base value for a lock write |
| cmdVict | input | CW | Victim value for a lock write |
| lockBase | output | CW | Current base index |
| lockVict | output | CW | Current victim index |
| loadBusy | output | 1 | Pulses for one cycle after a refused load |
| camOut | output | 32 | CAM word of the entry at the victim index |
| ramOut | output | 32 | RAM word of the entry at the victim index |

## Verification
The bench builds the block with four entries. At that size the victim index wraps after a handful of loads, and the base can be driven all the way to the entry count within a short directed run, so the wrap-to-base rule and the refused-load case are both reached. Every size code is swept across its page start, its last byte, one past its end and one byte before its start, with expected translations computed arithmetically. A 16 MB entry overlapping a 4 KB entry exercises the lowest-index rule and span-based flushing at both edges of a span.

// File: rtl/xlat_tlb_pkg.sv
package xlat_tlb_pkg;

  typedef enum logic [2:0] {
    OP_NOP        = 3'd0,
    OP_LOAD       = 3'd1,
    OP_FLUSH_ADDR = 3'd2,
    OP_FLUSH_ALL  = 3'd3,
    OP_SET_LOCK   = 3'd4
  } tlbOp_e;

  // strobes from control to the entry store
  typedef struct packed {
    logic wrEn;
    logic flushAddr;
    logic flushAll;
  } tlbStrobe_t;

  localparam int CAM_PIN_BIT = 3;

  // bits that are compared or translated for a given size code
  function automatic logic [31:0] spanMask(input logic [1:0] sizeCode);
    case (sizeCode)
      2'd0:    spanMask = 32'hFFFF_F000;
      2'd1:    spanMask = 32'hFFFF_0000;
      2'd2:    spanMask = 32'hFFF0_0000;
      default: spanMask = 32'hFF00_0000;
    endcase
  endfunction

endpackage

// File: rtl/xlat_tlb_ctrl.sv
module xlat_tlb_ctrl
  import xlat_tlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int CW      = 6
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cmdValid,
  input  logic [2:0]    cmdOp,
  input  logic          camPin,
  input  logic [CW-1:0] cmdBase,
  input  logic [CW-1:0] cmdVict,
  output tlbStrobe_t    strobe,
  output logic [CW-1:0] wrIdx,
  output logic [CW-1:0] lockBase,
  output logic [CW-1:0] lockVict,
  output logic          loadBusy
);

  localparam logic [CW-1:0] FULL = CW'(ENTRIES);

  tlbOp_e        op;
  logic          isLoad;
  logic          full;
  logic [CW-1:0] nextBase;
  logic [CW-1:0] nextVict;

  always_comb begin
    op     = tlbOp_e'(cmdOp);
    full   = (lockBase == FULL);
    isLoad = cmdValid && (op == OP_LOAD);

    strobe           = '0;
    strobe.wrEn      = isLoad && !full;
    strobe.flushAddr = cmdValid && (op == OP_FLUSH_ADDR);
    strobe.flushAll  = cmdValid && (op == OP_FLUSH_ALL);
    wrIdx            = camPin ? lockBase : lockVict;

    nextBase = lockBase;
    nextVict = lockVict;
    if (strobe.wrEn) begin
      if (camPin) begin
        nextBase = lockBase + CW'(1);
        nextVict = lockBase + CW'(1);
      end else begin
        nextVict = lockVict + CW'(1);
      end
      if (nextVict >= FULL) nextVict = nextBase;
    end else if (strobe.flushAll) begin
      nextBase = '0;
      nextVict = '0;
    end else if (cmdValid && (op == OP_SET_LOCK)) begin
      nextBase = cmdBase;
      nextVict = cmdVict;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockBase <= '0;
      lockVict <= '0;
      loadBusy <= 1'b0;
    end else begin
      lockBase <= nextBase;
      lockVict <= nextVict;
      loadBusy <= isLoad && full;
    end
  end

endmodule

// File: rtl/xlat_tlb_store.sv
module xlat_tlb_store
  import xlat_tlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int CW      = 6
) (
  input  logic          clk,
  input  logic          rstN,
  input  tlbStrobe_t    strobe,
  input  logic [CW-1:0] wrIdx,
  input  logic [31:0]   camIn,
  input  logic [31:0]   ramIn,
  input  logic [31:0]   flushAddr,
  input  logic          lkReq,
  input  logic [31:0]   lkAddr,
  input  logic [CW-1:0] rdIdx,
  output logic          lkHit,
  output logic          lkMiss,
  output logic [31:0]   lkPhys,
  output logic [31:0]   camOut,
  output logic [31:0]   ramOut
);

  localparam int IDXW = $clog2(ENTRIES);

  logic        vld    [ENTRIES];
  logic [27:0] camHi  [ENTRIES];
  logic [1:0]  sizeCd [ENTRIES];
  logic [31:0] ramW   [ENTRIES];

  logic [ENTRIES-1:0] lkMatch;
  logic [ENTRIES-1:0] flMatch;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_match
    logic [31:0] mask;
    logic [31:0] start;
    assign mask       = spanMask(sizeCd[g]);
    assign start      = {camHi[g][27:8], 12'h000} & mask;
    assign lkMatch[g] = vld[g] && ((lkAddr & mask) == start);
    assign flMatch[g] = vld[g] && ((flushAddr & mask) == start);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) begin
        vld[i]    <= 1'b0;
        camHi[i]  <= '0;
        sizeCd[i] <= '0;
        ramW[i]   <= '0;
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (strobe.flushAll) begin
          vld[i] <= 1'b0;
        end else if (strobe.wrEn && (wrIdx == CW'(i))) begin
          vld[i]    <= camIn[2];
          camHi[i]  <= camIn[31:4];
          sizeCd[i] <= camIn[1:0];
          ramW[i]   <= ramIn;
        end else if (strobe.flushAddr && flMatch[i]) begin
          vld[i] <= 1'b0;
        end
      end
    end
  end

  // priority pick: lowest matching index wins
  logic            hitAny;
  logic [IDXW-1:0] sel;
  logic [31:0]     selMask;
  logic [31:0]     physNext;

  always_comb begin
    hitAny = 1'b0;
    sel    = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (lkMatch[i]) begin
        hitAny = 1'b1;
        sel    = IDXW'(i);
      end
    end
    selMask  = spanMask(sizeCd[sel]);
    physNext = (ramW[sel] & selMask & 32'hFFFF_F000) | (lkAddr & ~selMask);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lkHit  <= 1'b0;
      lkMiss <= 1'b0;
      lkPhys <= '0;
    end else begin
      lkHit  <= lkReq && hitAny;
      lkMiss <= lkReq && !hitAny;
      lkPhys <= (lkReq && hitAny) ? physNext : 32'h0;
    end
  end

  // read-back of the entry named by the victim index
  always_comb begin
    camOut = '0;
    ramOut = '0;
    if (rdIdx < CW'(ENTRIES)) begin
      camOut = {camHi[rdIdx[IDXW-1:0]], 1'b0, vld[rdIdx[IDXW-1:0]],
                sizeCd[rdIdx[IDXW-1:0]]};
      ramOut = ramW[rdIdx[IDXW-1:0]];
    end
  end

endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
  import xlat_tlb_pkg::*;
#(
  parameter  int ENTRIES = 32,
  localparam int CW      = $clog2(ENTRIES) + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          lkReq,
  input  logic [31:0]   lkAddr,
  output logic          lkHit,
  output logic          lkMiss,
  output logic [31:0]   lkPhys,
  input  logic          cmdValid,
  input  logic [2:0]    cmdOp,
  input  logic [31:0]   cmdCam,
  input  logic [31:0]   cmdRam,
  input  logic [31:0]   cmdAddr,
  input  logic [CW-1:0] cmdBase,
  input  logic [CW-1:0] cmdVict,
  output logic [CW-1:0] lockBase,
  output logic [CW-1:0] lockVict,
  output logic          loadBusy,
  output logic [31:0]   camOut,
  output logic [31:0]   ramOut
);

  tlbStrobe_t    strobe;
  logic [CW-1:0] wrIdx;

  xlat_tlb_ctrl #(.ENTRIES(ENTRIES), .CW(CW)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdOp    (cmdOp),
    .camPin   (cmdCam[CAM_PIN_BIT]),
    .cmdBase  (cmdBase),
    .cmdVict  (cmdVict),
    .strobe   (strobe),
    .wrIdx    (wrIdx),
    .lockBase (lockBase),
    .lockVict (lockVict),
    .loadBusy (loadBusy)
  );

  xlat_tlb_store #(.ENTRIES(ENTRIES), .CW(CW)) u_store (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrIdx     (wrIdx),
    .camIn     (cmdCam),
    .ramIn     (cmdRam),
    .flushAddr (cmdAddr),
    .lkReq     (lkReq),
    .lkAddr    (lkAddr),
    .rdIdx     (lockVict),
    .lkHit     (lkHit),
    .lkMiss    (lkMiss),
    .lkPhys    (lkPhys),
    .camOut    (camOut),
    .ramOut    (ramOut)
  );

endmodule

// File: rtl/xlat_tlb_chk.sv
module xlat_tlb_chk
  import xlat_tlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int CW      = 6
) (
  input logic          clk,
  input logic          rstN,
  input logic          lkReq,
  input logic [31:0]   lkAddr,
  input logic          lkHit,
  input logic          lkMiss,
  input logic [31:0]   lkPhys,
  input logic          cmdValid,
  input logic [2:0]    cmdOp,
  input logic [31:0]   cmdCam,
  input logic [31:0]   cmdRam,
  input logic [31:0]   cmdAddr,
  input logic [CW-1:0] cmdBase,
  input logic [CW-1:0] cmdVict,
  input logic [CW-1:0] lockBase,
  input logic [CW-1:0] lockVict,
  input logic          loadBusy,
  input logic [31:0]   camOut,
  input logic [31:0]   ramOut
);

  localparam logic [CW-1:0] FULL = CW'(ENTRIES);

  AST_HIT_MISS_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(lkHit && lkMiss)); // R2

  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    lkMiss |-> (lkPhys == 32'h0)); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !lkReq |=> (!lkHit && !lkMiss)); // R2

  AST_FLUSH_ALL_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == OP_FLUSH_ALL) |=> (lockBase == '0 && lockVict == '0)); // R8

  AST_FULL_REFUSE: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == OP_LOAD && lockBase == FULL)
      |=> (loadBusy && $stable(lockBase) && $stable(lockVict))); // R6

  AST_PIN_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == OP_LOAD && cmdCam[CAM_PIN_BIT] && lockBase < FULL)
      |=> (lockBase == $past(lockBase) + CW'(1))); // R5

  AST_PLAIN_KEEPS_BASE: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == OP_LOAD && !cmdCam[CAM_PIN_BIT]) |=> $stable(lockBase)); // R4

endmodule

bind xlat_tlb xlat_tlb_chk #(.ENTRIES(ENTRIES), .CW(CW)) u_chk (.*);

// File: tb/xlat_tlb_bench.sv
`timescale 1ns/1ps
module xlat_tlb_bench;

  localparam int N  = 4;
  localparam int CW = $clog2(N) + 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          lkReq = 1'b0;
  logic [31:0]   lkAddr = '0;
  logic          lkHit, lkMiss;
  logic [31:0]   lkPhys;
  logic          cmdValid = 1'b0;
  logic [2:0]    cmdOp = '0;
  logic [31:0]   cmdCam = '0, cmdRam = '0, cmdAddr = '0;
  logic [CW-1:0] cmdBase = '0, cmdVict = '0;
  logic [CW-1:0] lockBase, lockVict;
  logic          loadBusy;
  logic [31:0]   camOut, ramOut;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  xlat_tlb #(.ENTRIES(N)) u_xlat_tlb (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] camW(input logic [31:0] tag, input bit pin,
                                       input bit vld, input logic [1:0] sz);
    camW = {tag[31:12], 8'h00, pin, vld, sz};
  endfunction

  task automatic doCmd(input logic [2:0] op, input logic [31:0] cam, input logic [31:0] ram,
                       input logic [31:0] addr, input logic [CW-1:0] b, input logic [CW-1:0] v);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdCam = cam; cmdRam = ram; cmdAddr = addr;
    cmdBase = b; cmdVict = v;
    @(posedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic load(input logic [31:0] tag, input bit pin, input logic [1:0] sz,
                      input logic [31:0] ram);
    doCmd(3'd1, camW(tag, pin, 1'b1, sz), ram, '0, '0, '0);
  endtask

  task automatic lookup(input logic [31:0] a);
    @(negedge clk);
    lkReq = 1'b1; lkAddr = a;
    @(posedge clk);
    @(negedge clk);
    lkReq = 1'b0;
  endtask

  task automatic expHit(input string tag, input logic [31:0] a, input logic [31:0] phys);
    lookup(a);
    chk({tag, " hit"}, {31'b0, lkHit}, 32'd1);
    chk({tag, " phys"}, lkPhys, phys);
  endtask

  task automatic expMiss(input string tag, input logic [31:0] a);
    lookup(a);
    chk({tag, " miss"}, {31'b0, lkMiss}, 32'd1);
    chk({tag, " hit"}, {31'b0, lkHit}, 32'd0);
    chk({tag, " phys"}, lkPhys, 32'd0);
  endtask

  task automatic expLock(input string tag, input int b, input int v);
    chk({tag, " base"}, 32'(lockBase), 32'(b));
    chk({tag, " vict"}, 32'(lockVict), 32'(v));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    expLock("R10", 0, 0);
    chk("R10 busy", {31'b0, loadBusy}, 32'd0);
    chk("R10 hit", {31'b0, lkHit}, 32'd0);
    chk("R10 camOut", camOut, 32'd0);
    expMiss("R10 empty", 32'h1234_5678);

    // R1 sweep of every size code
    for (int s = 0; s < 4; s++) begin
      logic [31:0] sz;
      logic [31:0] v, p;
      sz = 32'h1000 << (4 * s);
      v = 32'h5A00_0000;
      p = 32'h1300_0000;
      doCmd(3'd3, '0, '0, '0, '0, '0);
      load(v, 1'b0, 2'(s), p | 32'h0000_0ABC);
      expLock("R4 after one load", 0, 1);
      expHit("R1 start", v, p);
      expHit("R1 last", v + sz - 1, p + sz - 1);
      expHit("R1 mid", v + (sz >> 1) + 32'h34, p + (sz >> 1) + 32'h34);
      expMiss("R2 past end", v + sz);
      expMiss("R2 before start", v - 1);
    end

    // R4 round robin over all entries
    doCmd(3'd3, '0, '0, '0, '0, '0);
    for (int k = 0; k < 5; k++) begin
      load(32'h4000_0000 + (k << 12), 1'b0, 2'd0, 32'h8000_0000 + (k << 12) + 32'h0A5);
      expLock("R4 rotate", 0, (k + 1) % N);
    end
    expMiss("R4 overwritten entry 0", 32'h4000_0000);
    expHit("R4 newest", 32'h4000_4010, 32'h8000_4010);
    // R9 read back entry 2
    doCmd(3'd4, '0, '0, '0, CW'(0), CW'(2));
    expLock("R9 lock write", 0, 2);
    chk("R9 camOut", camOut, 32'h4000_2004);
    chk("R9 ramOut", ramOut, 32'h8000_20A5);

    // R5 pinned region, R4 wrap to base, R6 refusal
    doCmd(3'd3, '0, '0, '0, '0, '0);
    load(32'hA000_0000, 1'b1, 2'd0, 32'h0100_0000);
    expLock("R5 pin A", 1, 1);
    load(32'hB000_0000, 1'b0, 2'd0, 32'h0200_0000);
    expLock("R4 B", 1, 2);
    load(32'hC000_0000, 1'b0, 2'd0, 32'h0300_0000);
    expLock("R4 C", 1, 3);
    load(32'hD000_0000, 1'b0, 2'd0, 32'h0400_0000);
    expLock("R4 wrap to base", 1, 1);
    load(32'hE000_0000, 1'b0, 2'd0, 32'h0500_0000);
    expLock("R4 E", 1, 2);
    expHit("R5 pinned survives", 32'hA000_0123, 32'h0100_0123);
    expMiss("R4 B replaced", 32'hB000_0000);
    expHit("R4 E", 32'hE000_0000, 32'h0500_0000);
    load(32'hF000_0000, 1'b1, 2'd0, 32'h0600_0000);
    expLock("R5 pin F", 2, 2);
    expMiss("R5 F at old base", 32'hE000_0000);
    expHit("R5 F", 32'hF000_0FFF, 32'h0600_0FFF);
    load(32'h1000_0000, 1'b1, 2'd0, 32'h0700_0000);
    expLock("R5 pin G", 3, 3);
    load(32'h2000_0000, 1'b1, 2'd0, 32'h0800_0000);
    expLock("R5 pin H full", 4, 4);
    load(32'h3000_0000, 1'b0, 2'd0, 32'h0900_0000);
    chk("R6 busy", {31'b0, loadBusy}, 32'd1);
    expLock("R6 unchanged", 4, 4);
    expMiss("R6 not written", 32'h3000_0000);
    chk("R6 busy clears", {31'b0, loadBusy}, 32'd0);
    expHit("R6 H kept", 32'h2000_0000, 32'h0800_0000);

    // R8 global flush
    doCmd(3'd3, '0, '0, '0, '0, '0);
    expLock("R8 lock cleared", 0, 0);
    expMiss("R8 A gone", 32'hA000_0000);

    // R3 priority and R7 span flush
    load(32'h7700_0000, 1'b0, 2'd3, 32'h2200_0000);
    load(32'h7712_3000, 1'b0, 2'd0, 32'h3300_0000);
    expHit("R3 lowest index", 32'h7712_3456, 32'h2212_3456);
    doCmd(3'd2, '0, '0, 32'h7740_0000, '0, '0);
    expHit("R7 large span flushed", 32'h7712_3456, 32'h3300_0456);
    expMiss("R7 large gone", 32'h7740_0000);
    doCmd(3'd2, '0, '0, 32'h7712_4000, '0, '0);
    expHit("R7 one past end keeps", 32'h7712_3456, 32'h3300_0456);
    doCmd(3'd2, '0, '0, 32'h7712_3FFF, '0, '0);
    expMiss("R7 last byte flushes", 32'h7712_3456);

    // R9 lock write then R8 flush, idle cycle quiet (R2)
    doCmd(3'd4, '0, '0, '0, CW'(2), CW'(3));
    expLock("R9 write", 2, 3);
    chk("R2 idle hit", {31'b0, lkHit}, 32'd0);
    chk("R2 idle miss", {31'b0, lkMiss}, 32'd0);
    doCmd(3'd3, '0, '0, '0, '0, '0);
    expLock("R8 after lock write", 0, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule